// File: doc/BRIEF.md
# Two-Wide Register Rename Stage

This block renames a decode group of up to two instructions per cycle for a machine with a unified physical register file. Each instruction, called slot A (older) and slot B (younger), carries two architectural source registers and an optional architectural destination. The stage reads the current mappings of all sources from a mapping table. It takes fresh physical registers for the destinations from a free pool. It outputs physical source tags, the new physical destination and the destination's previous mapping, which is later handed back through the commit port when the instruction retires.

Dependences inside the group are resolved alongside the table read. If slot B reads a register that slot A writes, B's source is redirected to A's new register. If both slots write the same register, B's previous mapping is A's new register, and the table keeps B's. When the pool cannot cover the group, the whole group stalls and no state changes.

Top module: `rename2w`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and physical registers 32 to 63 are free.
- R2: Each physical source tag is the newest mapping of its architectural source, as left by all earlier accepted groups.
- R3: Allocation takes the lowest-numbered free physical register. When both slots write, slot A takes the lowest and slot B the next lowest. Results appear on the output with `ren_valid` high on the cycle after the group is accepted.
- R4: When slot B reads the architectural register that slot A writes, B's source tag is A's new physical register.
- R5: When both slots write the same architectural register, B's previous mapping is A's new register, and later readers see B's register.
- R6: For every writing slot, the previous-mapping output holds the physical register that the destination mapped to before this group.
- R7: `grp_stall` is high in the same cycle when a valid group needs more registers than are free. A stalled group produces no output and changes neither the table nor the pool.
- R8: Architectural register 0 is never renamed. A write to it allocates nothing and outputs pdst=0 and pold=0, and a read of it always gives physical register 0.
- R9: A commit with `cmt_valid` high returns `cmt_preg` to the pool, and it can be allocated from the next cycle on. A commit of register 0 is ignored.
- R10: A slot with its write enable low allocates nothing and outputs pdst=0 and pold=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A decode group is presented |
| grp_stall | output | 1 | Group cannot be accepted this cycle |
| a_src1 | input | 5 | Slot A first source |
| a_src2 | input | 5 | Slot A second source |
| a_dst | input | 5 | Slot A destination |
| a_wen | input | 1 | Slot A writes a register |
| b_src1 | input | 5 | Slot B first source |
| b_src2 | input | 5 | Slot B second source |
| b_dst | input | 5 | Slot B destination |
| b_wen | input | 1 | Slot B writes a register |
| cmt_valid | input | 1 | Commit frees a register |
| cmt_preg | input | 6 | Physical register being freed |
| ren_valid | output | 1 | Renamed group valid |
| a_psrc1 | output | 6 | Slot A first physical source |
| a_psrc2 | output | 6 | Slot A second physical source |
| a_pdst | output | 6 | Slot A new physical destination |
| a_pold | output | 6 | Slot A previous mapping |
| b_psrc1 | output | 6 | Slot B first physical source |
| b_psrc2 | output | 6 | Slot B second physical source |
| b_pdst | output | 6 | Slot B new physical destination |
| b_pold | output | 6 | Slot B previous mapping |

## Verification
`grp_stall` is combinational and is checked 1 ns after the inputs change, in the same cycle. Renamed tags are registered once, so they are checked 1 ns after the next rising edge, and the monitor compares each `ren_valid` beat against the head of the expected queue. Any beat that arrives with an empty queue is a failure, so a stalled group that leaks an output is caught. A freed register is expected to be usable by the group presented on the negative edge after the commit edge, and the bench model frees it at that same point.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int ARCH_N = 32;
    localparam int PHYS_N = 64;
    localparam int AW     = $clog2(ARCH_N);
    localparam int PW     = $clog2(PHYS_N);
    localparam int RD_N   = 6;   // three lookups per slot

    typedef logic [AW-1:0] areg_t;
    typedef logic [PW-1:0] preg_t;

    typedef struct packed {
        preg_t ps1;
        preg_t ps2;
        preg_t pd;
        preg_t pold;
    } ren_tags_t;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table
    import rn_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  areg_t rd_a [RD_N],
    output preg_t rd_p [RD_N],
    input  logic  wr_en [2],
    input  areg_t wr_a [2],
    input  preg_t wr_p [2]
);
    preg_t tbl_d [ARCH_N];
    preg_t tbl_q [ARCH_N];

    always_comb begin
        tbl_d = tbl_q;
        // slot 1 written last so it wins on a shared destination
        for (int k = 0; k < 2; k++) begin
            if (wr_en[k] && wr_a[k] != '0) tbl_d[wr_a[k]] = wr_p[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_N; i++) tbl_q[i] <= preg_t'(i);
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar j = 0; j < RD_N; j++) begin : g_rd
        assign rd_p[j] = tbl_q[rd_a[j]];
    end

    // R8
    zero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_q[0] == '0);
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
    import rn_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  need_a,
    input  logic  need_b,
    input  logic  take,
    input  logic  cmt_v,
    input  preg_t cmt_p,
    output logic  enough,
    output preg_t grant_a,
    output preg_t grant_b
);
    logic [PHYS_N-1:0] pool_d, pool_q;
    preg_t first, second;
    logic  got0, got1;

    always_comb begin
        first  = '0;
        second = '0;
        got0   = 1'b0;
        got1   = 1'b0;
        for (int i = 0; i < PHYS_N; i++) begin
            if (pool_q[i]) begin
                if (!got0) begin
                    first = preg_t'(i);
                    got0  = 1'b1;
                end else if (!got1) begin
                    second = preg_t'(i);
                    got1   = 1'b1;
                end
            end
        end
        grant_a = first;
        grant_b = need_a ? second : first;
        enough  = (need_a && need_b) ? got1 : ((need_a || need_b) ? got0 : 1'b1);
    end

    always_comb begin
        pool_d = pool_q;
        if (take && need_a) pool_d[grant_a] = 1'b0;
        if (take && need_b) pool_d[grant_b] = 1'b0;
        if (cmt_v && cmt_p != '0) pool_d[cmt_p] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_N; i++) pool_q[i] <= (i >= ARCH_N);
        end else begin
            pool_q <= pool_d;
        end
    end

    // R3
    distinct_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && need_a && need_b) |-> (pool_q[grant_a] && pool_q[grant_b] && grant_a != grant_b));
    // R9
    commit_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_v && cmt_p != '0) |=> pool_q[$past(cmt_p)]);
endmodule

// File: rtl/rn_dep_check.sv
module rn_dep_check
    import rn_pkg::*;
(
    input  logic  a_w,
    input  areg_t a_dst,
    input  preg_t a_new,
    input  areg_t b_s1,
    input  areg_t b_s2,
    input  areg_t b_dst,
    input  preg_t b_s1_tbl,
    input  preg_t b_s2_tbl,
    input  preg_t b_old_tbl,
    output preg_t b_s1_fix,
    output preg_t b_s2_fix,
    output preg_t b_old_fix
);
    always_comb begin
        b_s1_fix  = (a_w && b_s1  == a_dst) ? a_new : b_s1_tbl;
        b_s2_fix  = (a_w && b_s2  == a_dst) ? a_new : b_s2_tbl;
        b_old_fix = (a_w && b_dst == a_dst) ? a_new : b_old_tbl;
    end
endmodule

// File: rtl/rename2w.sv
module rename2w
    import rn_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        grp_valid,
    output logic        grp_stall,
    input  logic [4:0]  a_src1,
    input  logic [4:0]  a_src2,
    input  logic [4:0]  a_dst,
    input  logic        a_wen,
    input  logic [4:0]  b_src1,
    input  logic [4:0]  b_src2,
    input  logic [4:0]  b_dst,
    input  logic        b_wen,
    input  logic        cmt_valid,
    input  logic [5:0]  cmt_preg,
    output logic        ren_valid,
    output logic [5:0]  a_psrc1,
    output logic [5:0]  a_psrc2,
    output logic [5:0]  a_pdst,
    output logic [5:0]  a_pold,
    output logic [5:0]  b_psrc1,
    output logic [5:0]  b_psrc2,
    output logic [5:0]  b_pdst,
    output logic [5:0]  b_pold
);
    typedef struct packed {
        logic      vld;
        ren_tags_t a;
        ren_tags_t b;
    } stage_t;

    stage_t st_d, st_q;
    logic   a_w, b_w, enough, take;
    preg_t  grant_a, grant_b;
    areg_t  rd_a [RD_N];
    preg_t  rd_p [RD_N];
    logic   wr_en [2];
    areg_t  wr_a [2];
    preg_t  wr_p [2];
    preg_t  b_s1_fix, b_s2_fix, b_old_fix;

    assign a_w  = a_wen && a_dst != '0;
    assign b_w  = b_wen && b_dst != '0;
    assign take = grp_valid && enough;
    assign grp_stall = grp_valid && !enough;

    assign rd_a[0] = a_src1;
    assign rd_a[1] = a_src2;
    assign rd_a[2] = a_dst;
    assign rd_a[3] = b_src1;
    assign rd_a[4] = b_src2;
    assign rd_a[5] = b_dst;

    assign wr_en[0] = take && a_w;
    assign wr_en[1] = take && b_w;
    assign wr_a[0]  = a_dst;
    assign wr_a[1]  = b_dst;
    assign wr_p[0]  = grant_a;
    assign wr_p[1]  = grant_b;

    rn_map_table u_map (
        .clk(clk), .rst_n(rst_n), .rd_a(rd_a), .rd_p(rd_p),
        .wr_en(wr_en), .wr_a(wr_a), .wr_p(wr_p)
    );

    rn_free_list u_pool (
        .clk(clk), .rst_n(rst_n), .need_a(a_w), .need_b(b_w), .take(take),
        .cmt_v(cmt_valid), .cmt_p(cmt_preg), .enough(enough),
        .grant_a(grant_a), .grant_b(grant_b)
    );

    rn_dep_check u_dep (
        .a_w(a_w), .a_dst(a_dst), .a_new(grant_a),
        .b_s1(b_src1), .b_s2(b_src2), .b_dst(b_dst),
        .b_s1_tbl(rd_p[3]), .b_s2_tbl(rd_p[4]), .b_old_tbl(rd_p[5]),
        .b_s1_fix(b_s1_fix), .b_s2_fix(b_s2_fix), .b_old_fix(b_old_fix)
    );

    always_comb begin
        st_d        = st_q;
        st_d.vld    = take;
        if (take) begin
            st_d.a.ps1  = rd_p[0];
            st_d.a.ps2  = rd_p[1];
            st_d.a.pd   = a_w ? grant_a : '0;
            st_d.a.pold = a_w ? rd_p[2] : '0;
            st_d.b.ps1  = b_s1_fix;
            st_d.b.ps2  = b_s2_fix;
            st_d.b.pd   = b_w ? grant_b : '0;
            st_d.b.pold = b_w ? b_old_fix : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ren_valid = st_q.vld;
    assign a_psrc1 = st_q.a.ps1;
    assign a_psrc2 = st_q.a.ps2;
    assign a_pdst  = st_q.a.pd;
    assign a_pold  = st_q.a.pold;
    assign b_psrc1 = st_q.b.ps1;
    assign b_psrc2 = st_q.b.ps2;
    assign b_pdst  = st_q.b.pd;
    assign b_pold  = st_q.b.pold;

    // R7
    stall_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_stall |=> !ren_valid);
    // R8
    zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && !grp_stall && a_wen && a_dst == '0) |=> (a_pdst == '0 && a_pold == '0));
    // R5
    waw_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && a_w && b_w && a_dst == b_dst) |=> (b_pold == a_pdst));
endmodule

// File: tb/tb_rename2w.sv
module tb_rename2w;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grp_valid = 1'b0, a_wen = 1'b0, b_wen = 1'b0, cmt_valid = 1'b0;
    logic [4:0] a_src1 = '0, a_src2 = '0, a_dst = '0, b_src1 = '0, b_src2 = '0, b_dst = '0;
    logic [5:0] cmt_preg = '0;
    logic grp_stall, ren_valid;
    logic [5:0] a_psrc1, a_psrc2, a_pdst, a_pold, b_psrc1, b_psrc2, b_pdst, b_pold;

    always #2.5 clk = ~clk;

    rename2w dut (.*);

    int checks = 0, fails = 0;
    logic [5:0] m_map [32];
    logic       m_free [64];
    logic [47:0] exp_q [$];
    string       tag_q [$];

    task automatic check(bit ok, string req, string act, string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    function automatic int lowest_free(int skip);
        for (int i = 0; i < 64; i++) if (m_free[i] && i != skip) return i;
        return -1;
    endfunction

    task automatic send(input logic [4:0] as1, as2, ad, input logic aw,
                        input logic [4:0] bs1, bs2, bd, input logic bw, input string req);
        bit wa, wb, ok;
        int pa, pb;
        logic [5:0] e [8];
        a_src1 = as1; a_src2 = as2; a_dst = ad; a_wen = aw;
        b_src1 = bs1; b_src2 = bs2; b_dst = bd; b_wen = bw;
        grp_valid = 1'b1;
        #1;
        wa = aw && ad != 0;
        wb = bw && bd != 0;
        pa = wa ? lowest_free(-1) : 0;
        pb = wb ? lowest_free(wa ? pa : -1) : 0;
        ok = !(pa < 0 || pb < 0);
        check(grp_stall == !ok, "R7", $sformatf("%0b", grp_stall), $sformatf("%0b", !ok));
        if (ok) begin
            e[0] = m_map[as1]; e[1] = m_map[as2];
            e[2] = wa ? 6'(pa) : 6'd0; e[3] = wa ? m_map[ad] : 6'd0;
            if (wa) begin m_map[ad] = 6'(pa); m_free[pa] = 1'b0; end
            e[4] = m_map[bs1]; e[5] = m_map[bs2];
            e[6] = wb ? 6'(pb) : 6'd0; e[7] = wb ? m_map[bd] : 6'd0;
            if (wb) begin m_map[bd] = 6'(pb); m_free[pb] = 1'b0; end
            exp_q.push_back({e[0], e[1], e[2], e[3], e[4], e[5], e[6], e[7]});
            tag_q.push_back(req);
        end
        @(negedge clk);
        grp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic commit(input logic [5:0] p);
        cmt_valid = 1'b1; cmt_preg = p;
        if (p != 0) m_free[p] = 1'b1;
        @(negedge clk);
        cmt_valid = 1'b0;
    endtask

    // monitor: pops one expected group per output beat
    always @(posedge clk) begin
        logic [47:0] act, exp;
        #1;
        if (rst_n && ren_valid) begin
            act = {a_psrc1, a_psrc2, a_pdst, a_pold, b_psrc1, b_psrc2, b_pdst, b_pold};
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 (unexpected output)", $sformatf("%h", act), "none");
            end else begin
                exp = exp_q.pop_front();
                check(act == exp, tag_q.pop_front(), $sformatf("%h", act), $sformatf("%h", exp));
            end
        end
    end

    initial begin
        #100000;
        check(1'b0, "watchdog", "timeout", "finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_map[i] = 6'(i);
        for (int i = 0; i < 64; i++) m_free[i] = (i >= 32);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ren_valid == 1'b0, "R1 reset", $sformatf("%0b", ren_valid), "0");
        // identity map, first allocations 32/33, RAW and WAW inside the group
        send(5, 7, 3, 1, 3, 9, 3, 1, "R1 R3 R4 R5 R6");
        // newest mapping of r3 is 33; zero register and non-writing slot
        send(3, 0, 0, 1, 0, 3, 4, 0, "R2 R8 R10");
        // B alone writes: takes lowest free
        send(3, 4, 6, 0, 6, 3, 6, 1, "R3 R10 R2");
        // RAW on second source only, distinct destinations
        send(1, 2, 8, 1, 9, 8, 10, 1, "R4 R6");
        // drain the pool with two-write groups
        for (int g = 0; g < 13; g++)
            send(5'(11 + g), 5'(g), 5'(11 + g), 1, 5'(g + 1), 5'(12 + g), 5'(12 + g), 1, "R3 R6");
        // one register left: a two-write group stalls, one-write succeeds
        send(1, 1, 2, 1, 1, 1, 4, 1, "R7");
        send(2, 2, 2, 1, 0, 0, 0, 0, "R3 R7");
        // pool empty: single write stalls
        send(1, 1, 5, 1, 0, 0, 0, 0, "R7");
        // freeing register 0 is ignored: still stalls
        commit(6'd0);
        send(1, 1, 5, 1, 0, 0, 0, 0, "R9 R7");
        // free two and allocate them lowest-first
        commit(6'd40);
        commit(6'd7);
        send(5, 5, 5, 1, 5, 5, 5, 1, "R9 R3 R5");
        send(5, 20, 0, 0, 5, 3, 0, 0, "R2 R10");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 pending", $sformatf("%0d", exp_q.size()), "0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule